// File: doc/BRIEF.md
# Host OUT Transaction Retry Controller

This block decides what happens after each attempt of one host-side OUT transaction on a transmit endpoint. The packet engine reports the device's answer to each attempt as a one-cycle strobe. The answer is an acknowledge, a NAK, a STALL, a missing reply (timeout) or a reply damaged by a CRC or bit-stuff error. The block keeps two separate counts. One counts NAKs against a programmable limit. The other counts consecutive attempts that drew no valid reply, and three of those end the transaction.

When another attempt is needed, the block sends the scheduler a one-cycle retry request and does not resend anything itself. The transaction can end in four ways: success, stall, NAK timeout or error. Each ending sets its own sticky flag, and an error also sends a one-cycle FIFO flush request. Software clears the flags by writing ones. Once no flag is left set, the block goes back to idle and waits for the next start.

Top module: `out_retry_ctrl`

## Requirements
- R1: After reset all four flags are 0, `busy` is 0, `irq` is 0, and neither `retryReq` nor `flushReq` is asserted.
- R2: `startTxn` in idle clears both counters and makes `busy` 1 on the next cycle. `startTxn` is ignored while a transaction is waiting or halted.
- R3: A NAK that does not reach the limit produces a `retryReq` pulse exactly one cycle wide, in the cycle after the strobe. The block then keeps waiting.
- R4: With `nakLimit` = N > 0, the N-th NAK of a transaction sets flag bit 3 (NAK timeout) and halts. It produces no retry and no flush. Timeouts and corrupted replies do not reset the NAK count.
- R5: With `nakLimit` = 0, NAKs never time out, and every NAK produces a retry.
- R6: A timeout strobe or a corrupted-reply strobe counts as a no-response attempt. The first two consecutive attempts produce a retry. The third produces a one-cycle `flushReq`, sets flag bit 2 (error) and halts. A NAK in between restarts this count.
- R7: A STALL sets flag bit 1 (stalled) and halts at once, with no retry and no flush.
- R8: An acknowledge sets flag bit 0 (done), clears both counters and halts, with no retry.
- R9: Flags are sticky. Each bit of `flagClr` clears the flag at the same position. The block returns to idle (`busy` 0) in the cycle after the last set flag is cleared. Clearing a flag that is not set changes nothing.
- R10: Handshake strobes that arrive while idle or halted are ignored. Flags, pulses and `busy` stay unchanged.
- R11: When several strobes arrive in the same cycle, the order of precedence is STALL, then acknowledge, then no-response (timeout or corrupted), then NAK.
- R12: `irq` is high exactly when any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startTxn | input | 1 | Begin a new transaction (honoured in idle only) |
| ackStb | input | 1 | Device acknowledged the packet |
| nakStb | input | 1 | Device answered NAK |
| stallStb | input | 1 | Device answered STALL |
| timeoutStb | input | 1 | No reply within the turnaround time |
| badPktStb | input | 1 | Reply had a CRC or bit-stuff error |
| nakLimit | input | 8 | NAKs allowed before timeout; 0 disables the timeout |
| flagClr | input | 4 | Write-one-to-clear per flag, same bit order as `flags` |
| retryReq | output | 1 | One-cycle request to reschedule the attempt |
| flushReq | output | 1 | One-cycle FIFO flush request |
| busy | output | 1 | Transaction waiting or halted on a flag |
| flags | output | 4 | Sticky flags: [0] done, [1] stalled, [2] error, [3] NAK timeout |
| irq | output | 1 | Any flag set |

## Verification
The bench builds the block with its default parameters: an 8-bit NAK limit and three no-response attempts. With these defaults a limit of 255 can be driven all the way to the top of the counter, and a run of 300 NAKs with the limit disabled makes the NAK counter wrap without a false timeout. The three-attempt error path is also short enough to mix freely with NAKs, so that NAKs landing between failed attempts test the restart of the no-response count.

// File: rtl/out_retry_pkg.sv
package out_retry_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HALT = 2'd2
  } txnState_e;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic clrAll;   // zero both counters
    logic bumpNak;  // count a NAK, restart the no-response count
    logic bumpErr;  // count a no-response attempt
  } cntCmd_t;

  localparam int FLAG_DONE  = 0;
  localparam int FLAG_STALL = 1;
  localparam int FLAG_ERROR = 2;
  localparam int FLAG_NAKTO = 3;
  localparam int FLAG_W     = 4;

endpackage

// File: rtl/out_retry_dp.sv
module out_retry_dp
  import out_retry_pkg::*;
#(
  parameter int NAK_W     = 8,
  parameter int ERR_TRIES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCmd_t          cmd,
  input  logic [NAK_W-1:0] nakLimit,
  output logic             nakLast,
  output logic             errLast
);
  localparam int ERR_W = $clog2(ERR_TRIES + 1);
  localparam logic [ERR_W-1:0] ERR_FINAL = ERR_W'(ERR_TRIES - 1);

  logic [NAK_W-1:0] nakCnt;
  logic [ERR_W-1:0] errCnt;
  logic [NAK_W:0]   nakNext;

  assign nakNext = {1'b0, nakCnt} + {{NAK_W{1'b0}}, 1'b1};
  assign nakLast = (nakLimit != '0) && (nakNext == {1'b0, nakLimit});
  assign errLast = (errCnt == ERR_FINAL);

  always_ff @(posedge clk) begin
    if (!rstN || cmd.clrAll) begin
      nakCnt <= '0;
      errCnt <= '0;
    end else if (cmd.bumpNak) begin
      nakCnt <= nakNext[NAK_W-1:0];
      errCnt <= '0;
    end else if (cmd.bumpErr) begin
      errCnt <= errLast ? '0 : errCnt + 1'b1;
    end
  end

  // R6
  err_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    errCnt < ERR_W'(ERR_TRIES));

  // R4
  nak_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.bumpNak && !cmd.clrAll) |=> (nakCnt == $past(nakNext[NAK_W-1:0])));

endmodule

// File: rtl/out_retry_fsm.sv
module out_retry_fsm
  import out_retry_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startTxn,
  input  logic              ackStb,
  input  logic              nakStb,
  input  logic              stallStb,
  input  logic              timeoutStb,
  input  logic              badPktStb,
  input  logic              nakLast,
  input  logic              errLast,
  input  logic [FLAG_W-1:0] flagClr,
  output cntCmd_t           cmd,
  output logic              retryReq,
  output logic              flushReq,
  output logic              busy,
  output logic [FLAG_W-1:0] flags
);
  txnState_e         state, nextState;
  logic [FLAG_W-1:0] setMask;
  logic              retryNext, flushNext;

  always_comb begin
    cmd       = '0;
    nextState = state;
    setMask   = '0;
    retryNext = 1'b0;
    flushNext = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startTxn) begin
          cmd.clrAll = 1'b1;
          nextState  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (stallStb) begin
          setMask[FLAG_STALL] = 1'b1;
          nextState           = ST_HALT;
        end else if (ackStb) begin
          setMask[FLAG_DONE] = 1'b1;
          cmd.clrAll         = 1'b1;
          nextState          = ST_HALT;
        end else if (timeoutStb || badPktStb) begin
          cmd.bumpErr = 1'b1;
          if (errLast) begin
            setMask[FLAG_ERROR] = 1'b1;
            flushNext           = 1'b1;
            nextState           = ST_HALT;
          end else begin
            retryNext = 1'b1;
          end
        end else if (nakStb) begin
          cmd.bumpNak = 1'b1;
          if (nakLast) begin
            setMask[FLAG_NAKTO] = 1'b1;
            nextState           = ST_HALT;
          end else begin
            retryNext = 1'b1;
          end
        end
      end
      ST_HALT: begin
        if ((flags & ~flagClr) == '0) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      flags    <= '0;
      retryReq <= 1'b0;
      flushReq <= 1'b0;
    end else begin
      state    <= nextState;
      flags    <= (flags & ~flagClr) | setMask;
      retryReq <= retryNext;
      flushReq <= flushNext;
    end
  end

  assign busy = (state != ST_IDLE);

  // R3
  retry_waiting_chk: assert property (@(posedge clk) disable iff (!rstN)
    retryReq |-> (state == ST_WAIT && flags == '0));

  // R6
  flush_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> (flags[FLAG_ERROR] && !retryReq));

  // R7
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[FLAG_STALL]) |-> (!retryReq && !flushReq));

  // R4
  nakto_noflush_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[FLAG_NAKTO]) |-> !flushReq);

  // R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(flags));

  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALT && flagClr == '0) |=> $stable(flags));

endmodule

// File: rtl/out_retry_ctrl.sv
module out_retry_ctrl
  import out_retry_pkg::*;
#(
  parameter int NAK_W     = 8,
  parameter int ERR_TRIES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startTxn,
  input  logic             ackStb,
  input  logic             nakStb,
  input  logic             stallStb,
  input  logic             timeoutStb,
  input  logic             badPktStb,
  input  logic [NAK_W-1:0] nakLimit,
  input  logic [3:0]       flagClr,
  output logic             retryReq,
  output logic             flushReq,
  output logic             busy,
  output logic [3:0]       flags,
  output logic             irq
);
  cntCmd_t cmd;
  logic    nakLast, errLast;

  out_retry_dp #(.NAK_W(NAK_W), .ERR_TRIES(ERR_TRIES)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .nakLimit(nakLimit),
    .nakLast(nakLast), .errLast(errLast)
  );

  out_retry_fsm uFsm (
    .clk(clk), .rstN(rstN), .startTxn(startTxn),
    .ackStb(ackStb), .nakStb(nakStb), .stallStb(stallStb),
    .timeoutStb(timeoutStb), .badPktStb(badPktStb),
    .nakLast(nakLast), .errLast(errLast), .flagClr(flagClr),
    .cmd(cmd), .retryReq(retryReq), .flushReq(flushReq),
    .busy(busy), .flags(flags)
  );

  assign irq = |flags;

  // R12
  irq_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($countones(flags) == 1));

endmodule

// File: tb/tb_out_retry_ctrl.sv
module tb_out_retry_ctrl;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN, startTxn, ackStb, nakStb, stallStb, timeoutStb, badPktStb;
  logic [7:0] nakLimit;
  logic [3:0] flagClr, flags;
  logic       retryReq, flushReq, busy, irq;

  out_retry_ctrl dut (
    .clk(clk), .rstN(rstN), .startTxn(startTxn), .ackStb(ackStb),
    .nakStb(nakStb), .stallStb(stallStb), .timeoutStb(timeoutStb),
    .badPktStb(badPktStb), .nakLimit(nakLimit), .flagClr(flagClr),
    .retryReq(retryReq), .flushReq(flushReq), .busy(busy),
    .flags(flags), .irq(irq)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // Reference model: 0 idle, 1 waiting, 2 halted
  int       mState = 0;
  int       mNak   = 0;
  int       mErr   = 0;
  logic [3:0] mFlags = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkOuts(input string req, input bit expRetry, input bit expFlush);
    chk(retryReq == expRetry, {req, " retryReq"}, retryReq, expRetry);
    chk(flushReq == expFlush, {req, " flushReq"}, flushReq, expFlush);
    chk(flags == mFlags, {req, " flags"}, flags, mFlags);
    chk(busy == (mState != 0), {req, " busy"}, busy, mState != 0);
    chk(irq == (|mFlags), {req, " R12 irq"}, irq, |mFlags);
  endtask

  // Model of one handshake cycle; mask bits: 0 ack, 1 nak, 2 stall, 3 timeout, 4 bad
  task automatic modelStep(input logic [4:0] m, output bit er, output bit ef);
    er = 0; ef = 0;
    if (mState != 1) return;
    if (m[2]) begin
      mFlags[1] = 1'b1; mState = 2;
    end else if (m[0]) begin
      mFlags[0] = 1'b1; mState = 2; mNak = 0; mErr = 0;
    end else if (m[3] || m[4]) begin
      mErr++;
      if (mErr == 3) begin
        mFlags[2] = 1'b1; ef = 1; mState = 2; mErr = 0;
      end else er = 1;
    end else if (m[1]) begin
      mErr = 0; mNak++;
      if (nakLimit != 0 && mNak == int'(nakLimit)) begin
        mFlags[3] = 1'b1; mState = 2;
      end else er = 1;
    end
  endtask

  task automatic pulse(input logic [4:0] m, input string req);
    bit er, ef;
    modelStep(m, er, ef);
    {badPktStb, timeoutStb, stallStb, nakStb, ackStb} = m;
    @(posedge clk); @(negedge clk);
    {badPktStb, timeoutStb, stallStb, nakStb, ackStb} = '0;
    checkOuts(req, er, ef);
  endtask

  task automatic doStart(input string req);
    if (mState == 0) begin mState = 1; mNak = 0; mErr = 0; end
    startTxn = 1'b1;
    @(posedge clk); @(negedge clk);
    startTxn = 1'b0;
    checkOuts(req, 0, 0);
  endtask

  task automatic doClear(input logic [3:0] c, input string req);
    mFlags = mFlags & ~c;
    if (mState == 2 && mFlags == 0) mState = 0;
    flagClr = c;
    @(posedge clk); @(negedge clk);
    flagClr = '0;
    checkOuts(req, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 0; startTxn = 0; ackStb = 0; nakStb = 0; stallStb = 0;
    timeoutStb = 0; badPktStb = 0; flagClr = '0; nakLimit = 8'd3;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    checkOuts("R1 reset", 0, 0);

    // R10: strobes in idle are ignored
    pulse(5'b00010, "R10 idle nak");
    pulse(5'b01000, "R10 idle timeout");

    // R2, R3, R4
    doStart("R2 start");
    doStart("R2 start while waiting");
    pulse(5'b00010, "R3 nak1");
    @(negedge clk);
    chk(retryReq == 0, "R3 pulse width", retryReq, 0);
    pulse(5'b01000, "R4 timeout keeps nak count");
    pulse(5'b00010, "R3 nak2");
    pulse(5'b00010, "R4 nak limit hit");
    pulse(5'b01000, "R10 halted timeout");
    pulse(5'b00001, "R10 halted ack");
    doStart("R2 start while halted");
    doClear(4'b0001, "R9 clear unset flag");
    doClear(4'b1000, "R9 clear nak timeout");

    // R5 and R6 with timeout disabled
    nakLimit = 8'd0;
    doStart("R2 start");
    for (int i = 0; i < 300; i++) pulse(5'b00010, "R5 unlimited nak");
    pulse(5'b01000, "R6 miss1");
    pulse(5'b10000, "R6 bad2");
    pulse(5'b00010, "R6 nak restarts count");
    pulse(5'b01000, "R6 miss1 again");
    pulse(5'b01000, "R6 miss2");
    pulse(5'b10000, "R6 third no-response flush");
    @(negedge clk);
    chk(flushReq == 0, "R6 flush width", flushReq, 0);
    doClear(4'b0100, "R9 clear error");

    doStart("R2 start");
    pulse(5'b00010, "R5 nak");
    pulse(5'b00100, "R7 stall");
    doClear(4'b0010, "R9 clear stall");

    nakLimit = 8'd2;
    doStart("R2 start");
    pulse(5'b00010, "R3 nak");
    pulse(5'b01000, "R6 miss");
    pulse(5'b00001, "R8 ack");
    doClear(4'b0001, "R9 clear done");
    doStart("R2 start");
    pulse(5'b00010, "R8 fresh count nak1");
    pulse(5'b00010, "R4 nak2 limit");
    doClear(4'b1111, "R9 clear all");

    // R11 precedence
    doStart("R2 start");
    pulse(5'b11111, "R11 stall first");
    doClear(4'b1111, "R9 clear");
    doStart("R2 start");
    pulse(5'b11011, "R11 ack over rest");
    doClear(4'b1111, "R9 clear");
    nakLimit = 8'd1;
    doStart("R2 start");
    pulse(5'b11010, "R11 no-response over nak");
    pulse(5'b00010, "R4 limit one");
    doClear(4'b1111, "R9 clear");

    // R4 at the top of the limit range
    nakLimit = 8'd255;
    doStart("R2 start");
    for (int i = 0; i < 255; i++) pulse(5'b00010, "R4 limit 255");
    doClear(4'b1111, "R9 clear");

    // Constrained random transactions
    for (int t = 0; t < 60; t++) begin
      nakLimit = ($urandom % 5 == 0) ? 8'd0 : 8'(($urandom % 5) + 1);
      doStart("R2 random start");
      for (int s = 0; s < 25 && mState == 1; s++) begin
        int r;
        logic [4:0] m;
        r = $urandom % 100;
        if (r < 40)      m = 5'b00010;
        else if (r < 55) m = 5'b01000;
        else if (r < 70) m = 5'b10000;
        else if (r < 80) m = 5'b00001;
        else if (r < 85) m = 5'b00100;
        else             m = 5'($urandom % 32);
        pulse(m, "random R3 R4 R6 R7 R8 R11");
      end
      doClear(4'($urandom % 16), "R9 random clear");
      doClear(4'b1111, "R9 final clear");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule